// File: doc/BRIEF.md
# Reversible-Gate Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands in one combinational pass. Its netlist uses only two reversible gate types. Each operand-B bit goes through a controlled-NOT (Feynman) gate whose control is the mode input. That gate passes the bit unchanged when the mode is low and inverts it when the mode is high. The mode input also serves as the carry into the least significant stage. Each stage is a four-line reversible full-adder gate (an HNG gate) with its fourth input tied to zero. Chaining these gates gives a ripple adder.

The block returns the result word, the carry out of the top stage and a signed overflow flag. Reversible gates must keep every output line, so the lines that carry no arithmetic result are gathered on a garbage bus. A caller that only wants arithmetic leaves that bus unconnected. A caller that models reversible hardware can observe it.

Top module: `rev_addsub`

## Requirements
- R1: With `sub_mode`=0, `result` equals (`opa` + `opb`) modulo 2^WIDTH.
- R2: With `sub_mode`=1, `result` equals (`opa` - `opb`) modulo 2^WIDTH, which is two's-complement subtraction.
- R3: With `sub_mode`=0, `carry_out` is 1 exactly when the unsigned sum of `opa` and `opb` is 2^WIDTH or more.
- R4: With `sub_mode`=1, `carry_out` is 1 exactly when `opa` >= `opb` as unsigned values, meaning no borrow occurred. In particular, 0 - 0 gives carry 1 and 0 - 1 gives carry 0.
- R5: In both modes, `ovf` is 1 exactly when the signed (two's-complement) result falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R6: For each bit i, the garbage bus holds the following: bit 3i is `opa[i]`, bit 3i+1 is `opb[i]` XOR `sub_mode`, and bit 3i+2 is `sub_mode`.
- R7: The outputs depend only on the present inputs. Every output settles within the same cycle the inputs change, and no state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand; subtracted when `sub_mode` is 1 |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the top stage; in subtract mode, 1 means no borrow |
| ovf | output | 1 | Signed overflow |
| garbage | output | 3*WIDTH | Unused reversible-gate lines, three per bit |

## Verification
The bench builds the block with the default WIDTH of 4. At that width every pairing of the two operands with both modes can be applied, 512 vectors in all, so the full input space is reachable. Each vector is compared against integer arithmetic computed in the bench for the result, the carry/borrow and the signed overflow. The signed overflow corners are also checked directly: most-positive plus one, most-negative minus one, and two most-negative values added. So are the zero-operand borrow cases and the garbage line layout.

// File: rtl/rvas_pkg.sv
package rvas_pkg;

  // Arithmetic model: returns {carry, result}, masked to w bits (w <= 32).
  function automatic logic [32:0] addsub_ref(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic        m,
                                             input int          w);
    logic [32:0] mask;
    logic [32:0] aa;
    logic [32:0] bb;
    logic [32:0] sum;
    logic [32:0] keep;
    mask = (33'd1 << w) - 33'd1;
    aa   = {1'b0, a} & mask;
    bb   = {1'b0, (m ? ~b : b)} & mask;
    sum  = aa + bb + {32'd0, m};
    keep = (mask << 1) | 33'd1;
    return sum & keep;
  endfunction

  // Signed overflow from operand and result sign bits.
  function automatic logic signed_ovf(input logic sa, input logic sb_eff,
                                      input logic sr);
    return (sa == sb_eff) && (sr != sa);
  endfunction

endpackage

// File: rtl/rvas_feynman.sv
module rvas_feynman (
  input  logic ctl_i,
  input  logic tgt_i,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = ctl_i ^ tgt_i;
endmodule

// File: rtl/rvas_hng.sv
module rvas_hng (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic p_o,
  output logic q_o,
  output logic r_o,
  output logic s_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign p_o  = a_i;
  assign q_o  = b_i;
  assign r_o  = ab_x ^ c_i;
  assign s_o  = (ab_x & c_i) ^ (a_i & b_i) ^ d_i;
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  input  logic               sub_mode,
  output logic [WIDTH-1:0]   result,
  output logic               carry_out,
  output logic               ovf,
  output logic [3*WIDTH-1:0] garbage
);
  localparam int GPB = 3;

  logic [WIDTH:0]   chain_c;
  logic [WIDTH-1:0] b_adj;
  logic [WIDTH-1:0] mode_copy;
  logic [WIDTH-1:0] pass_a;
  logic [WIDTH-1:0] pass_b;

  assign chain_c[0] = sub_mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    rvas_feynman u_fg (
      .ctl_i (sub_mode),
      .tgt_i (opb[i]),
      .ctl_o (mode_copy[i]),
      .tgt_o (b_adj[i])
    );
    rvas_hng u_fa (
      .a_i (opa[i]),
      .b_i (b_adj[i]),
      .c_i (chain_c[i]),
      .d_i (1'b0),
      .p_o (pass_a[i]),
      .q_o (pass_b[i]),
      .r_o (result[i]),
      .s_o (chain_c[i+1])
    );
    assign garbage[GPB*i]   = pass_a[i];
    assign garbage[GPB*i+1] = pass_b[i];
    assign garbage[GPB*i+2] = mode_copy[i];
  end

  assign carry_out = chain_c[WIDTH];
  assign ovf       = chain_c[WIDTH-1] ^ chain_c[WIDTH];
endmodule

// File: rtl/rev_addsub_chk.sv
module rev_addsub_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]   opa,
  input logic [WIDTH-1:0]   opb,
  input logic               sub_mode,
  input logic [WIDTH-1:0]   result,
  input logic               carry_out,
  input logic               ovf,
  input logic [3*WIDTH-1:0] garbage
);
  logic [32:0] ref_v;
  logic        ovf_ref;
  assign ref_v   = rvas_pkg::addsub_ref(32'(opa), 32'(opb), sub_mode, WIDTH);
  assign ovf_ref = rvas_pkg::signed_ovf(opa[WIDTH-1], opb[WIDTH-1] ^ sub_mode,
                                        ref_v[WIDTH-1]);

  always_comb begin
    AST_ADD_RESULT: assert (sub_mode || result == ref_v[WIDTH-1:0]); // R1
    AST_SUB_RESULT: assert (!sub_mode || result == ref_v[WIDTH-1:0]); // R2
    AST_ADD_CARRY: assert (sub_mode || carry_out == ref_v[WIDTH]); // R3
    AST_NO_BORROW: assert (!sub_mode || carry_out == (opa >= opb)); // R4
    AST_SIGNED_OVF: assert (ovf == ovf_ref); // R5
    for (int i = 0; i < WIDTH; i++) begin
      AST_GARBAGE_MAP: assert (garbage[3*i] == opa[i] &&
                               garbage[3*i+1] == (opb[i] ^ sub_mode) &&
                               garbage[3*i+2] == sub_mode); // R6
    end
  end
endmodule

bind rev_addsub rev_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .sub_mode  (sub_mode),
  .result    (result),
  .carry_out (carry_out),
  .ovf       (ovf),
  .garbage   (garbage)
);

// File: tb/rev_addsub_tb.sv
module rev_addsub_tb;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int GW   = 3 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  opa = '0;
  logic [W-1:0]  opb = '0;
  logic          sub_mode = 1'b0;
  logic [W-1:0]  result;
  logic          carry_out;
  logic          ovf;
  logic [GW-1:0] garbage;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 8 ns period

  rev_addsub #(.WIDTH(W)) u_dut (
    .opa(opa), .opb(opb), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out), .ovf(ovf), .garbage(garbage)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d m=%0d)",
               req, act, exp, opa, opb, sub_mode);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= SPAN / 2) ? v - SPAN : v;
  endfunction

  // Drive after a rising edge, sample at the following falling edge.
  task automatic apply(input int a, input int b, input bit m);
    @(posedge clk);
    opa      = W'(a);
    opb      = W'(b);
    sub_mode = m;
    @(negedge clk);
  endtask

  task automatic check_arith(input int a, input int b, input bit m);
    int er, sr;
    bit ec, eo;
    er = m ? ((a - b) % SPAN + SPAN) % SPAN : (a + b) % SPAN;
    ec = m ? (a >= b) : ((a + b) >= SPAN);
    sr = m ? sgn(a) - sgn(b) : sgn(a) + sgn(b);
    eo = (sr > SPAN / 2 - 1) || (sr < -(SPAN / 2));
    if (m) begin
      chk(int'(result) == er, "R2", int'(result), er);
      chk(carry_out == ec, "R4", int'(carry_out), int'(ec));
    end else begin
      chk(int'(result) == er, "R1", int'(result), er);
      chk(carry_out == ec, "R3", int'(carry_out), int'(ec));
    end
    chk(ovf == eo, "R5", int'(ovf), int'(eo));
  endtask

  task automatic t_idle_state();
    apply(0, 0, 1'b0);
    chk(result == '0, "R7", int'(result), 0);
    chk(carry_out == 1'b0, "R7", int'(carry_out), 0);
    chk(ovf == 1'b0, "R7", int'(ovf), 0);
    chk(garbage == '0, "R6", int'(garbage), 0);
  endtask

  task automatic t_add_all();
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++) begin
        apply(a, b, 1'b0);
        check_arith(a, b, 1'b0);
      end
  endtask

  task automatic t_sub_all();
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++) begin
        apply(a, b, 1'b1);
        check_arith(a, b, 1'b1);
      end
  endtask

  task automatic t_corners();
    apply(SPAN / 2 - 1, 1, 1'b0);            // max positive + 1
    chk(ovf == 1'b1, "R5", int'(ovf), 1);
    apply(SPAN / 2, 1, 1'b1);                // min negative - 1
    chk(ovf == 1'b1, "R5", int'(ovf), 1);
    apply(SPAN / 2, SPAN / 2, 1'b0);         // min + min
    chk(ovf == 1'b1, "R5", int'(ovf), 1);
    chk(carry_out == 1'b1, "R3", int'(carry_out), 1);
    apply(0, 0, 1'b1);                       // 0 - 0: no borrow
    chk(carry_out == 1'b1, "R4", int'(carry_out), 1);
    chk(result == '0, "R2", int'(result), 0);
    apply(0, 1, 1'b1);                       // 0 - 1: borrow
    chk(carry_out == 1'b0, "R4", int'(carry_out), 0);
    chk(int'(result) == SPAN - 1, "R2", int'(result), SPAN - 1);
  endtask

  task automatic t_garbage();
    for (int v = 0; v < 4; v++) begin
      int a = (v * 5 + 3) % SPAN;
      int b = (v * 7 + 9) % SPAN;
      bit m = v[0];
      logic [GW-1:0] eg;
      apply(a, b, m);
      for (int i = 0; i < W; i++) begin
        eg[3*i]   = a[i];
        eg[3*i+1] = b[i] ^ m;
        eg[3*i+2] = m;
      end
      chk(garbage == eg, "R6", int'(garbage), int'(eg));
    end
  endtask

  task automatic t_same_cycle();
    apply(3, 4, 1'b0);
    chk(result == W'(7), "R7", int'(result), 7);
    apply(3, 4, 1'b1);
    chk(int'(result) == SPAN - 1, "R7", int'(result), SPAN - 1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle_state();
    t_add_all();
    t_sub_all();
    t_corners();
    t_garbage();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule